// File: doc/BRIEF.md
# SAR ADC conversion frame sequencer

This controller sits between a system clock domain and an external dual-channel successive-approximation converter. It produces the control timing for that converter and nothing else. A request starts a frame. During the frame the block drives a gated converter clock, divided from the system clock, and issues an active-low conversion-start strobe. It then counts a fixed number of converter clock edges: twelve conversion cycles, one pre-charge cycle, two sampling cycles and one cycle of setup and hold margin, so a conversion frame has sixteen clocks. A register-write request runs a shorter frame of fourteen edges with no strobe. Between frames the converter clock is parked low.

The converter clock has a period of `DIV` system clocks, and `DIV` must be even. The strobe falls when a frame is accepted. That is half a converter period before the first rising edge, which meets the converter's setup time at any legal ratio. The strobe rises again on the first falling edge.

A request that arrives while `busy_o` is high is not refused outright. One such request is held in a single slot and starts its frame one cycle after the current frame finishes. A further request while that slot is full is dropped and reported on `overrun_o`.

Top module: `adc_frame_seq`

## Requirements
- R1: During and right after reset, `conv_clk_o` is 0, `conv_start_n_o` is 1, and `busy_o`, `done_o` and `overrun_o` are 0.
- R2: Within a frame, every high phase and every low phase of `conv_clk_o` lasts exactly `DIV/2` system clocks, which gives a 50% duty cycle.
- R3: A conversion frame, requested on `start_i`, delivers exactly `CONV_EDGES` (16) rising and 16 falling converter clock edges. `conv_clk_o` then stays low.
- R4: A register-write frame, requested on `reg_wr_i`, delivers exactly `REG_EDGES` (14) rising and 14 falling edges, and `conv_start_n_o` stays 1 throughout.
- R5: In a conversion frame, `conv_start_n_o` goes low in the first frame cycle, `DIV/2` system clocks before the first rising edge. It is still low at that rising edge and returns high at the first falling edge, so it is low for `DIV` cycles. It is never low outside a frame.
- R6: `busy_o` is high from the cycle after a request is accepted until the last falling edge, which lasts edges×`DIV` system clocks. `done_o` pulses for one cycle in the cycle `busy_o` falls.
- R7: A request made while `busy_o` is high is held. Its frame starts one cycle after `done_o`, and frames run in request order. A new strobe only ever falls at the start of a frame.
- R8: A request made while busy and while another request is already held is discarded, produces no frame, and raises `overrun_o` for one cycle on the following clock.
- R9: `start_i` and `reg_wr_i` high in the same cycle count as one conversion request.
- R10: Whenever `busy_o` is low, `conv_clk_o` is 0 and `conv_start_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion frame request, one-cycle pulse |
| reg_wr_i | input | 1 | Register-write frame request, one-cycle pulse |
| conv_clk_o | output | 1 | Gated converter clock, parked low when idle |
| conv_start_n_o | output | 1 | Active-low conversion-start strobe |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| overrun_o | output | 1 | One-cycle pulse when a request is discarded |

## Verification
Two functions can fall in the same cycle. The first is the end of a running frame, which sets `done_o` and drops `busy_o`. The second is the acceptance of a held request, together with a fresh request arriving while a request is still held. The bench provokes this by issuing a register write and then another conversion request during one conversion frame, so one request is held and the next overruns. The scoreboard then expects exactly one extra frame, of register-write shape, starting right after `done_o`, and exactly one overrun pulse. Every frame is judged at its `done_o` against the queued kind, by counting edges, phase lengths, strobe cycles and busy cycles.

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
  parameter int DIV        = 4,
  parameter int CONV_EDGES = 16,
  parameter int REG_EDGES  = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic reg_wr_i,
  output logic conv_clk_o,
  output logic conv_start_n_o,
  output logic busy_o,
  output logic done_o,
  output logic overrun_o
);
  localparam int HALF = DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int TW   = $clog2(2 * CONV_EDGES + 1);

  logic [HW-1:0] ph_q;
  logic [TW-1:0] tog_q;
  logic active_q, conv_q, pend_q, pend_conv_q;
  logic sclk_q, cnv_n_q, done_q, ovr_q;

  wire          req         = start_i | reg_wr_i;
  wire          ph_end      = (ph_q == HW'(HALF - 1));
  wire [TW-1:0] tog_nxt     = tog_q + 1'b1;
  wire [TW-1:0] last_tog    = conv_q ? TW'(2 * CONV_EDGES) : TW'(2 * REG_EDGES);
  wire          launch      = !active_q && (pend_q || req);
  wire          launch_conv = pend_q ? pend_conv_q : start_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      conv_q      <= 1'b0;
      pend_q      <= 1'b0;
      pend_conv_q <= 1'b0;
      sclk_q      <= 1'b0;
      cnv_n_q     <= 1'b1;
      done_q      <= 1'b0;
      ovr_q       <= 1'b0;
      ph_q        <= '0;
      tog_q       <= '0;
    end else begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      if (launch) begin
        active_q    <= 1'b1;
        conv_q      <= launch_conv;
        cnv_n_q     <= !launch_conv;
        sclk_q      <= 1'b0;
        ph_q        <= '0;
        tog_q       <= '0;
        pend_q      <= pend_q & req;
        pend_conv_q <= start_i;
      end else if (active_q) begin
        if (req) begin
          if (pend_q) ovr_q <= 1'b1;
          else begin
            pend_q      <= 1'b1;
            pend_conv_q <= start_i;
          end
        end
        if (ph_end) begin
          ph_q   <= '0;
          sclk_q <= !sclk_q;
          tog_q  <= tog_nxt;
          if (sclk_q) cnv_n_q <= 1'b1;
          if (tog_nxt == last_tog) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  assign conv_clk_o     = sclk_q;
  assign conv_start_n_o = cnv_n_q;
  assign busy_o         = active_q;
  assign done_o         = done_q;
  assign overrun_o      = ovr_q;
endmodule

// File: rtl/adc_frame_seq_chk.sv
module adc_frame_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_clk_o,
  input logic conv_start_n_o,
  input logic busy_o,
  input logic done_o,
  input logic overrun_o
);
  AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!conv_clk_o && conv_start_n_o)); // R10
  AST_STROBE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start_n_o |-> busy_o); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o)); // R6
  AST_OVERRUN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> $past(busy_o)); // R8
  AST_RISE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_clk_o) |-> busy_o); // R3
  AST_STROBE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_start_n_o) |-> $rose(busy_o)); // R7
endmodule

bind adc_frame_seq adc_frame_seq_chk u_chk (.*);

// File: tb/adc_frame_seq_test.sv
module adc_frame_seq_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, reg_wr_i = 1'b0;
  logic conv_clk_o, conv_start_n_o, busy_o, done_o, overrun_o;

  adc_frame_seq #(.DIV(DIV)) uut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  bit exp_q[$];
  int idle_bad = 0, ovr_seen = 0;

  task automatic chk(input string r, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic do_req(input bit conv, input bit both, input bit push);
    @(negedge clk);
    start_i  = conv | both;
    reg_wr_i = !conv | both;
    if (push) exp_q.push_back(conv | both);
    @(negedge clk);
    start_i  = 1'b0;
    reg_wr_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || busy_o);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  int cyc, rises, falls, lowcnt, run, bad_run;
  bit prev_clk = 0, prev_busy = 0, in_fr = 0, strobe_r1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy_o && (conv_clk_o || !conv_start_n_o)) idle_bad++;
      if (overrun_o) ovr_seen++;
      if (busy_o && !prev_busy) begin
        in_fr = 1; cyc = 0; rises = 0; falls = 0; lowcnt = 0; run = 0; bad_run = 0; strobe_r1 = 0;
      end
      if (in_fr) begin
        if (busy_o) cyc++;
        if (!conv_start_n_o) lowcnt++;
        if (conv_clk_o != prev_clk) begin
          if (run != HALF) bad_run++;
          run = 1;
          if (conv_clk_o) begin
            if (rises == 0) strobe_r1 = !conv_start_n_o;
            rises++;
          end else falls++;
        end else run++;
        if (done_o) begin
          in_fr = 0;
          if (exp_q.size() == 0) chk("R7", "unexpected frame", 1, 0);
          else begin
            bit c;
            int e;
            c = exp_q.pop_front();
            e = c ? 16 : 14;
            chk(c ? "R3" : "R4", "rising edges", rises, e);
            chk(c ? "R3" : "R4", "falling edges", falls, e);
            chk("R2", "bad phase lengths", bad_run, 0);
            chk("R6", "busy cycles", cyc, e * DIV);
            chk(c ? "R5" : "R4", "strobe low cycles", lowcnt, c ? DIV : 0);
            chk("R5", "strobe low at first rise", strobe_r1, c);
          end
        end
      end
      prev_clk  = conv_clk_o;
      prev_busy = busy_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "conv_clk", conv_clk_o, 0);
    chk("R1", "strobe_n", conv_start_n_o, 1);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "done", done_o, 0);
    chk("R1", "overrun", overrun_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy_o, 0);

    do_req(1, 0, 1);             // R3 plain conversion
    wait_idle();
    do_req(0, 0, 1);             // R4 register write
    wait_idle();
    do_req(1, 0, 1);             // R7 held request
    repeat (10) @(negedge clk);
    do_req(0, 0, 1);
    wait_idle();
    do_req(1, 0, 1);             // R8 held + overrun
    repeat (5) @(negedge clk);
    do_req(0, 0, 1);
    repeat (5) @(negedge clk);
    do_req(1, 0, 0);
    wait_idle();
    do_req(0, 1, 1);             // R9 simultaneous requests
    wait_idle();
    do_req(0, 0, 1);             // R7 held conversion after register write
    repeat (4) @(negedge clk);
    do_req(1, 0, 1);
    wait_idle();

    chk("R8", "overrun pulses", ovr_seen, 1);
    chk("R10", "idle parking violations", idle_bad, 0);
    chk("R7", "frames left unserved", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule